// File: doc/BRIEF.md
# Interrupt Aggregation Controller

This block gathers the status of four sequencer engines and drives two host interrupt lines. Each engine supplies three inputs: a level saying its receive queue holds data, a level saying its transmit queue has room, and requests to raise any of eight shared event flags. The flags sit in an internal register. The host clears them with write-one-to-clear accesses and forces them with write-one-to-set accesses. Any engine may raise any flag, so a flag number does not identify an engine. Only the low four flags reach the host status. The upper four stay internal for engine-to-engine signalling.

The engine levels and the four visible flags form a 12-bit raw status vector. Each of the two host lines has its own enable mask and force mask. Its masked status is (raw AND enable) OR force, and its interrupt output is the registered OR of that masked status. The host reaches every register through a simple valid/write/address/data port. Read data appears on the cycle after the request and holds until the next read.

Top module: `irq_combiner`

## Requirements
- R1: After synchronous reset, all flags, enable masks and force masks are zero, both interrupt lines are low and the read data is zero.
- R2: A read at address 2 returns the raw status. Bits 3:0 are receive-not-empty for engines 0..3. Bits 7:4 are transmit-not-full for engines 0..3. Bits 11:8 are flags 3:0. Bits 15:12 read zero. Enable and force masks have no effect on it.
- R3: Reads at addresses 0 and 1 return all eight flags in bits 7:0. Flags 7:4 never appear in the raw status.
- R4: A write to address 0 clears every flag whose data bit 7:0 is 1 and leaves the other flags unchanged.
- R5: A write to address 1 sets every flag whose data bit 7:0 is 1 and leaves the other flags unchanged.
- R6: Input byte e of the set-request bus (bits 8e+7..8e) lets engine e set any flag. When a set request and a host clear hit the same flag in the same cycle, the flag ends set.
- R7: Line L has its enable mask at address 4+4L and its force mask at 5+4L, each 12 bits wide. A read at 6+4L returns (raw AND enable) OR force.
- R8: A force mask changes only its own line's masked status and interrupt. It does not change the flags or the other line.
- R9: host_irq[L] equals the OR of line L's masked status as it stood at the previous clock edge.
- R10: Read data is registered. Unmapped addresses read zero. Writes never change the read data. Writes to addresses 2, 6 and 10 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_rx_nempty | input | 4 | Receive-queue-not-empty level per engine |
| eng_tx_nfull | input | 4 | Transmit-queue-not-full level per engine |
| eng_flag_set | input | 32 | Flag set requests, one byte per engine |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| flag_state | output | 8 | Current flags as seen by the engines |
| host_irq | output | 2 | Host interrupt lines |

## Verification
Random engine levels, sparse set requests and random register traffic run against a bench model. This shows whether each raw bit reaches the right field of the status and whether masking uses AND with the enable mask and OR with the force mask. Directed cases apply a set and a clear to the same flag in one cycle, which separates set-wins from clear-wins. One case forces only the upper flags and checks they stay out of the raw status. One case forces a single line and checks the other line stays low and the flags stay unchanged. A final case writes to a read-only address and reads an unmapped one.

// File: rtl/irq_combiner_pkg.sv
package irq_combiner_pkg;
  localparam int unsigned ADDR_W     = 4;
  localparam int unsigned LINE_STEP  = 4;
  localparam logic [ADDR_W-1:0] A_FLAG_CLR = 4'd0;
  localparam logic [ADDR_W-1:0] A_FLAG_SET = 4'd1;
  localparam logic [ADDR_W-1:0] A_RAW      = 4'd2;

  typedef enum logic [1:0] {
    L_ENABLE = 2'd0,
    L_FORCE  = 2'd1,
    L_MASKED = 2'd2,
    L_NONE   = 2'd3
  } line_reg_e;

  function automatic logic [ADDR_W-1:0] line_base(input int unsigned line);
    return ADDR_W'(LINE_STEP * (line + 1));
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned NUM_ENG  = 4,
  parameter int unsigned NUM_FLAG = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_ENG*NUM_FLAG-1:0]  set_req,
  input  logic                         clr_we,
  input  logic                         frc_we,
  input  logic [NUM_FLAG-1:0]          wmask,
  output logic [NUM_FLAG-1:0]          flags
);
  logic [NUM_FLAG-1:0] set_any;
  logic [NUM_FLAG-1:0] clr_bits;
  logic [NUM_FLAG-1:0] frc_bits;

  always_comb begin
    set_any = '0;
    for (int e = 0; e < int'(NUM_ENG); e++)
      set_any = set_any | set_req[e*NUM_FLAG +: NUM_FLAG];
    clr_bits = clr_we ? wmask : '0;
    frc_bits = frc_we ? wmask : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr_bits) | frc_bits | set_any;
  end

  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((flags & $past(wmask & ~set_any)) == '0));
  assert_force_R5: assert property (@(posedge clk) disable iff (rst)
    frc_we |=> ((flags & $past(wmask)) == $past(wmask)));
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (|set_any) |=> ((flags & $past(set_any)) == $past(set_any)));
endmodule

// File: rtl/irq_out_line.sv
module irq_out_line #(
  parameter int unsigned RAW_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RAW_W-1:0] raw,
  input  logic             en_we,
  input  logic             frc_we,
  input  logic [RAW_W-1:0] wdata,
  output logic [RAW_W-1:0] en_q,
  output logic [RAW_W-1:0] frc_q,
  output logic [RAW_W-1:0] masked,
  output logic             irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      frc_q <= '0;
    end else begin
      if (en_we)  en_q  <= wdata;
      if (frc_we) frc_q <= wdata;
    end
  end

  assign masked = (raw & en_q) | frc_q;

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |masked;
  end

  assert_enable_load_R7: assert property (@(posedge clk) disable iff (rst)
    en_we |=> (en_q == $past(wdata)));
  assert_force_raises_R9: assert property (@(posedge clk) disable iff (rst)
    (frc_q != '0) |=> irq_o);
  assert_quiet_low_R9: assert property (@(posedge clk) disable iff (rst)
    (((raw & en_q) == '0) && (frc_q == '0)) |=> !irq_o);
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irq_combiner_pkg::*;
#(
  parameter int unsigned NUM_ENG  = 4,
  parameter int unsigned NUM_FLAG = 8,
  parameter int unsigned NUM_LINE = 2,
  parameter int unsigned DATA_W   = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_ENG-1:0]          eng_rx_nempty,
  input  logic [NUM_ENG-1:0]          eng_tx_nfull,
  input  logic [NUM_ENG*NUM_FLAG-1:0] eng_flag_set,
  input  logic                        reg_valid,
  input  logic                        reg_write,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  output logic [NUM_FLAG-1:0]         flag_state,
  output logic [NUM_LINE-1:0]         host_irq
);
  localparam int unsigned VIS_W = NUM_ENG;
  localparam int unsigned RAW_W = 3 * NUM_ENG;

  logic wr_en;
  logic rd_en;
  assign wr_en = reg_valid && reg_write;
  assign rd_en = reg_valid && !reg_write;

  logic [NUM_FLAG-1:0] flags;
  logic [RAW_W-1:0]    raw;

  irq_flag_bank #(.NUM_ENG(NUM_ENG), .NUM_FLAG(NUM_FLAG)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_req (eng_flag_set),
    .clr_we  (wr_en && reg_addr == A_FLAG_CLR),
    .frc_we  (wr_en && reg_addr == A_FLAG_SET),
    .wmask   (reg_wdata[NUM_FLAG-1:0]),
    .flags   (flags)
  );

  assign flag_state = flags;
  assign raw = {flags[VIS_W-1:0], eng_tx_nfull, eng_rx_nempty};

  logic [RAW_W-1:0] en_v  [NUM_LINE];
  logic [RAW_W-1:0] frc_v [NUM_LINE];
  logic [RAW_W-1:0] msk_v [NUM_LINE];

  for (genvar l = 0; l < int'(NUM_LINE); l++) begin : g_line
    localparam logic [ADDR_W-1:0] BASE = line_base(l);
    irq_out_line #(.RAW_W(RAW_W)) u_line (
      .clk    (clk),
      .rst    (rst),
      .raw    (raw),
      .en_we  (wr_en && reg_addr == BASE),
      .frc_we (wr_en && reg_addr == BASE + ADDR_W'(1)),
      .wdata  (reg_wdata[RAW_W-1:0]),
      .en_q   (en_v[l]),
      .frc_q  (frc_v[l]),
      .masked (msk_v[l]),
      .irq_o  (host_irq[l])
    );
  end

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (reg_addr == A_FLAG_CLR || reg_addr == A_FLAG_SET)
      rd_next = DATA_W'(flags);
    else if (reg_addr == A_RAW)
      rd_next = DATA_W'(raw);
    for (int l = 0; l < int'(NUM_LINE); l++) begin
      if (reg_addr == line_base(l) + ADDR_W'(L_ENABLE)) rd_next = DATA_W'(en_v[l]);
      if (reg_addr == line_base(l) + ADDR_W'(L_FORCE))  rd_next = DATA_W'(frc_v[l]);
      if (reg_addr == line_base(l) + ADDR_W'(L_MASKED)) rd_next = DATA_W'(msk_v[l]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        reg_rdata <= '0;
    else if (rd_en) reg_rdata <= rd_next;
  end

  assert_raw_pad_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_addr == A_RAW) |=> (reg_rdata[DATA_W-1:RAW_W] == '0));
  assert_write_keeps_rdata_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> $stable(reg_rdata));
  assert_hidden_flags_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_addr == A_RAW) |=> (reg_rdata[RAW_W-1:2*NUM_ENG] == $past(flag_state[VIS_W-1:0])));
endmodule

// File: tb/sim_irq_combiner.sv
module sim_irq_combiner;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0]  rx = '0, tx = '0;
  logic [31:0] setreq = '0;
  logic        v = 1'b0, w = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wd = '0;
  logic [15:0] rdata;
  logic [7:0]  fstate;
  logic [1:0]  irq;

  int total = 0, bad = 0;
  logic [7:0]  m_flags = '0;
  logic [11:0] m_en [2] = '{12'h0, 12'h0};
  logic [11:0] m_frc[2] = '{12'h0, 12'h0};
  logic [15:0] m_rd = '0;

  always #10 clk = ~clk;

  irq_combiner u0 (
    .clk(clk), .rst(rst), .eng_rx_nempty(rx), .eng_tx_nfull(tx),
    .eng_flag_set(setreq), .reg_valid(v), .reg_write(w), .reg_addr(addr),
    .reg_wdata(wd), .reg_rdata(rdata), .flag_state(fstate), .host_irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [11:0] raw_of(input logic [3:0] r, input logic [3:0] t, input logic [7:0] f);
    return {f[3:0], t, r};
  endfunction

  function automatic logic [15:0] read_of(input logic [3:0] a, input logic [11:0] rw);
    case (a)
      4'd0, 4'd1: return {8'h0, m_flags};
      4'd2:  return {4'h0, rw};
      4'd4:  return {4'h0, m_en[0]};
      4'd5:  return {4'h0, m_frc[0]};
      4'd6:  return {4'h0, (rw & m_en[0]) | m_frc[0]};
      4'd8:  return {4'h0, m_en[1]};
      4'd9:  return {4'h0, m_frc[1]};
      4'd10: return {4'h0, (rw & m_en[1]) | m_frc[1]};
      default: return 16'h0;
    endcase
  endfunction

  // Called at a negedge; drives one cycle and checks the outcome at the next negedge.
  task automatic step(input string tag, input logic iv, input logic iw, input logic [3:0] ia,
                      input logic [15:0] iwd, input logic [3:0] irx, input logic [3:0] itx,
                      input logic [31:0] iset);
    logic [11:0] rw;
    logic [1:0]  exp_irq;
    logic [7:0]  set_any;
    v = iv; w = iw; addr = ia; wd = iwd; rx = irx; tx = itx; setreq = iset;
    rw = raw_of(irx, itx, m_flags);
    for (int l = 0; l < 2; l++) exp_irq[l] = |((rw & m_en[l]) | m_frc[l]);
    if (iv && !iw) m_rd = read_of(ia, rw);
    @(posedge clk);
    set_any = iset[7:0] | iset[15:8] | iset[23:16] | iset[31:24];
    if (iv && iw) begin
      case (ia)
        4'd0: m_flags = m_flags & ~iwd[7:0];
        4'd1: m_flags = m_flags | iwd[7:0];
        4'd4: m_en[0]  = iwd[11:0];
        4'd5: m_frc[0] = iwd[11:0];
        4'd8: m_en[1]  = iwd[11:0];
        4'd9: m_frc[1] = iwd[11:0];
        default: ;
      endcase
    end
    m_flags = m_flags | set_any;
    @(negedge clk);
    v = 1'b0; setreq = '0;
    check({tag, "/R9 irq"}, 32'(irq), 32'(exp_irq));
    check({tag, "/R10 rdata"}, 32'(rdata), 32'(m_rd));
    check({tag, "/R3 flags"}, 32'(fstate), 32'(m_flags));
  endtask

  task automatic rd(input string tag, input logic [3:0] a);
    step(tag, 1'b1, 1'b0, a, 16'h0, rx, tx, 32'h0);
  endtask

  task automatic wr(input string tag, input logic [3:0] a, input logic [15:0] d);
    step(tag, 1'b1, 1'b1, a, d, rx, tx, 32'h0);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 rdata", 32'(rdata), 0);
    check("R1 flags", 32'(fstate), 0);
    rd("R1", 4'd4);
    rd("R1", 4'd9);

    // R2/R3: hidden flags do not reach raw; R5 force sets
    wr("R5", 4'd1, 16'h00F0);
    step("R2", 1'b1, 1'b0, 4'd2, 16'h0, 4'h5, 4'hA, 32'h0);
    check("R2 raw layout", 32'(rdata), 32'h0A5);
    rd("R3", 4'd0);
    check("R3 hidden flags", 32'(rdata), 32'h00F0);

    // R4: clear only selected bits
    wr("R4", 4'd0, 16'h0030);
    rd("R4", 4'd1);
    check("R4 clear", 32'(rdata), 32'h00C0);

    // R6: engine 3 sets flag 2 while host clears flag 2
    step("R6", 1'b1, 1'b1, 4'd0, 16'h0004, 4'h0, 4'h0, 32'h0400_0000);
    check("R6 set wins", 32'(fstate[2]), 1);

    // R8: force line 1 only
    wr("R8", 4'd9, 16'h0800);
    step("R8", 1'b0, 1'b0, 4'd0, 16'h0, 4'h0, 4'h0, 32'h0);
    check("R8 line1 high", 32'(irq[1]), 1);
    check("R8 line0 low", 32'(irq[0]), 0);
    check("R8 flags kept", 32'(fstate), 32'h00C4);
    rd("R8", 4'd10);
    check("R8 masked1", 32'(rdata), 32'h0800);

    // R7: enable line 0 on raw bit 8 (flag 0)
    wr("R7", 4'd4, 16'h0100);
    wr("R7", 4'd1, 16'h0001);
    rd("R7", 4'd6);
    check("R7 masked0", 32'(rdata), 32'h0100);

    // R10: write to read-only raw and unmapped read
    wr("R10", 4'd2, 16'hFFFF);
    rd("R10", 4'd15);
    check("R10 unmapped", 32'(rdata), 0);
    wr("R10", 4'd0, 16'h00FF);
    wr("R10", 4'd9, 16'h0000);
    wr("R10", 4'd4, 16'h0000);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  a;
      logic [31:0] s;
      logic        op_v, op_w;
      a    = 4'($urandom_range(0, 11));
      op_v = ($urandom_range(0, 3) != 0);
      op_w = $urandom_range(0, 1);
      s    = ($urandom_range(0, 7) == 0) ? (32'h1 << $urandom_range(0, 31)) : 32'h0;
      step("R7 rnd", op_v, op_w, a, 16'($urandom), 4'($urandom), 4'($urandom), s);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule